// File: doc/BRIEF.md
# Raster sync timing generator

This block is the timing master of a composite video encoder. From one pixel clock it produces the whole raster: a pixel counter that spans one line and a line counter that spans one field or frame. Its outputs are active-low horizontal and vertical sync, a gate for the colour burst, a gate for picture content and an odd/even field flag. Three standards are supported: 525-line NTSC, 625-line PAL, and PAL60, which uses the PAL colour system on 525-line timing. Each standard works with either of two clock families. The first family runs at 13.5 or 27 MHz. The second runs at the rate that suits the standard.

The standard is chosen from two select pins. A second-family select changes all pixel positions inside a line. Scan can be interlaced, where a field holds a whole number of lines plus one half line. It can also be progressive. In progressive mode every field repeats odd-field timing and is half a line shorter or longer than an interlaced field. The raster starts from pixel 0 of line 0 as soon as reset is released. The selects are static control pins. A change to them takes effect cleanly only through a reset.

All pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and nothing can stall it.

Top module: `raster_sync_gen`

## Requirements
- R1: The standard is NTSC when `std_625` is 0. It is PAL when `std_625` is 1 and `pal_full` is 1, and PAL60 when `std_625` is 1 and `pal_full` is 0. A line lasts 858/910 clocks (NTSC), 864/908 (PAL) or 858/902 (PAL60) for `clk_family` = 0/1.
- R2: `hsync_n` is low from pixel 0 up to, but not including, pixel 64 (first family) or pixel 67 (second family) of every line.
- R3: `burst_gate` is high from pixel 71 to pixel 105 in the first family. In the second family it is high from pixel 76 (NTSC) or 75 (PAL, PAL60) to pixel 111.
- R4: `active_gate` is high from pixel 128/135 (NTSC, PAL60) or 142/149 (PAL) to the end of the line. It stays low on every blanked line. The blanked lines are the first `BLANK_525`/`BLANK_625` lines of each field (default 19/23). In the even field they are frame lines F to F+BLANK.
- R5: With `interlace` = 1 a frame lasts 2F+1 lines, where F = `FIELD_525` or `FIELD_625` (default 262/312). That gives 262.5 or 312.5 lines per field. The even-field vertical sync falls at pixel L/2 of frame line F.
- R6: With `interlace` = 0 a field lasts F lines, or F+1 lines when `add_half` is 1. Every field has odd timing: `vsync_n` falls in the same cycle as `hsync_n`.
- R7: `vsync_n` stays low for exactly `VSYNC_LINES` whole lines (default 3), counted from the point where it falls.
- R8: `field_odd` is 1 through the odd field and 0 through the even field. It changes only where vertical sync falls. In progressive mode it stays 1.
- R9: While `rst_n` is low, `hsync_n` and `vsync_n` are 1, both gates are 0 and `field_odd` is 1. The first clock edge with `rst_n` high starts the raster, so the following cycle is pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset; its release sets the timing origin |
| std_625 | input | 1 | Standard select: 0 selects NTSC, 1 selects the PAL group |
| pal_full | input | 1 | Within the PAL group: 1 selects PAL, 0 selects PAL60 |
| clk_family | input | 1 | Clock-family select (0 first, 1 second) |
| interlace | input | 1 | 1 selects interlaced scan, 0 selects progressive |
| add_half | input | 1 | Progressive only: 1 adds a line, 0 drops the half line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| burst_gate | output | 1 | High during the burst window |
| active_gate | output | 1 | High during picture content |
| field_odd | output | 1 | 1 during the odd field, 0 during the even field |

## Verification
Every output is compared in every cycle against a model in the bench. That model computes the frame position of each pixel, rather than counting lines, across at least one full frame plus one line. Directed runs cover all three standards in both clock families. Between them they cover both scan modes and both `add_half` values, so a wrong table entry, a wrong frame length or a misplaced half-line sync shows up as a mismatch. Seeded random mode mixes are added on top. To keep run time short the bench shrinks the field and blank line counts, while the per-line pixel tables keep their real values. A reset check before each run confirms the idle output levels and the start-of-raster alignment.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int HW = 10;

  typedef enum logic [1:0] {STD_NTSC = 2'd0, STD_PAL = 2'd1, STD_PAL60 = 2'd2} std_e;

  typedef struct packed {
    logic [HW-1:0] len;
    logic [HW-1:0] sync_end;
    logic [HW-1:0] burst_beg;
    logic [HW-1:0] burst_end;
    logic [HW-1:0] act_beg;
  } htime_t;

  function automatic htime_t h_table(std_e s, logic fam);
    htime_t t;
    t.sync_end  = fam ? HW'(67)  : HW'(64);
    t.burst_end = fam ? HW'(112) : HW'(106);
    t.burst_beg = fam ? HW'(75)  : HW'(71);
    t.act_beg   = fam ? HW'(135) : HW'(128);
    case (s)
      STD_NTSC: begin
        t.len = fam ? HW'(910) : HW'(858);
        if (fam) t.burst_beg = HW'(76);
      end
      STD_PAL: begin
        t.len     = fam ? HW'(908) : HW'(864);
        t.act_beg = fam ? HW'(149) : HW'(142);
      end
      default: t.len = fam ? HW'(902) : HW'(858);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/rsg_mode_dec.sv
module rsg_mode_dec
  import rsg_pkg::*;
(
  input  logic   std_625,
  input  logic   pal_full,
  input  logic   clk_family,
  output std_e   std,
  output htime_t ht
);
  always_comb begin
    if (!std_625)     std = STD_NTSC;
    else if (pal_full) std = STD_PAL;
    else               std = STD_PAL60;
    ht = h_table(std, clk_family);
  end
endmodule

// File: rtl/rsg_hcount.sv
module rsg_hcount
  import rsg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  htime_t        ht,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          hsync_n,
  output logic          burst_gate,
  output logic          act_h
);
  logic last_pix;
  assign last_pix = (hcnt >= ht.len - HW'(1));
  assign line_end = run && last_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hcnt <= '0;
    else if (run)    hcnt <= last_pix ? '0 : hcnt + HW'(1);
  end

  assign hsync_n    = !(run && (hcnt < ht.sync_end));
  assign burst_gate = run && (hcnt >= ht.burst_beg) && (hcnt < ht.burst_end);
  assign act_h      = run && (hcnt >= ht.act_beg);

  // R1: a line end is followed by pixel 0
  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));
  // R3: burst never overlaps horizontal sync
  assert_burst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_gate |-> hsync_n);
endmodule

// File: rtl/rsg_vcount.sv
module rsg_vcount
  import rsg_pkg::*;
#(
  parameter int FIELD_525   = 262,
  parameter int FIELD_625   = 312,
  parameter int BLANK_525   = 19,
  parameter int BLANK_625   = 23,
  parameter int VSYNC_LINES = 3,
  parameter int LW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_end,
  input  logic [HW-1:0] hcnt,
  input  logic [HW-1:0] half_pos,
  input  std_e          std,
  input  logic          interlace,
  input  logic          add_half,
  output logic          vsync_n,
  output logic          field_odd,
  output logic          line_blank
);
  logic [LW-1:0] lcnt, fl, bl, frame_lines, vsl;
  logic          past_half, odd_v, even_v;

  assign fl  = (std == STD_PAL) ? LW'(FIELD_625) : LW'(FIELD_525);
  assign bl  = (std == STD_PAL) ? LW'(BLANK_625) : LW'(BLANK_525);
  assign vsl = LW'(VSYNC_LINES);
  assign frame_lines = interlace ? (fl + fl + LW'(1)) : (fl + LW'(add_half));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lcnt <= '0;
    else if (line_end) lcnt <= (lcnt >= frame_lines - LW'(1)) ? '0 : lcnt + LW'(1);
  end

  assign past_half = (hcnt >= half_pos);
  assign odd_v  = (lcnt < vsl);
  assign even_v = interlace && (((lcnt == fl) && past_half) ||
                                ((lcnt > fl) && (lcnt < fl + vsl)) ||
                                ((lcnt == fl + vsl) && !past_half));
  assign vsync_n   = !(run && (odd_v || even_v));
  assign field_odd = !(interlace && (((lcnt == fl) && past_half) || (lcnt > fl)));
  assign line_blank = (lcnt < bl) || (interlace && (lcnt >= fl) && (lcnt <= fl + bl));

  // R8: in interlaced scan each vertical sync flips the field flag
  assert_field_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (interlace && $past(run) && $fell(vsync_n)) |-> (field_odd != $past(field_odd)));
  // R5: line counter stays inside the frame
  assert_line_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt < frame_lines);
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int FIELD_525   = 262,
  parameter int FIELD_625   = 312,
  parameter int BLANK_525   = 19,
  parameter int BLANK_625   = 23,
  parameter int VSYNC_LINES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_625,
  input  logic pal_full,
  input  logic clk_family,
  input  logic interlace,
  input  logic add_half,
  output logic hsync_n,
  output logic vsync_n,
  output logic burst_gate,
  output logic active_gate,
  output logic field_odd
);
  localparam int LW = $clog2(2 * FIELD_625 + 2);

  std_e          std;
  htime_t        ht;
  logic          run, line_end, act_h, line_blank;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  rsg_mode_dec u_dec (
    .std_625(std_625), .pal_full(pal_full), .clk_family(clk_family),
    .std(std), .ht(ht)
  );

  rsg_hcount u_h (
    .clk(clk), .rst_n(rst_n), .run(run), .ht(ht), .hcnt(hcnt),
    .line_end(line_end), .hsync_n(hsync_n), .burst_gate(burst_gate), .act_h(act_h)
  );

  rsg_vcount #(
    .FIELD_525(FIELD_525), .FIELD_625(FIELD_625), .BLANK_525(BLANK_525),
    .BLANK_625(BLANK_625), .VSYNC_LINES(VSYNC_LINES), .LW(LW)
  ) u_v (
    .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end), .hcnt(hcnt),
    .half_pos(ht.len >> 1), .std(std), .interlace(interlace), .add_half(add_half),
    .vsync_n(vsync_n), .field_odd(field_odd), .line_blank(line_blank)
  );

  assign active_gate = act_h && !line_blank;

  // R6: progressive vertical sync always starts together with horizontal sync
  assert_prog_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!interlace && $fell(vsync_n)) |-> $fell(hsync_n));
  // R4: picture gate never overlaps sync or burst
  assert_active_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_gate |-> (hsync_n && !burst_gate));
  // R9: before the raster starts every output is idle
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync_n && vsync_n && !burst_gate && !active_gate && field_odd));
endmodule

// File: tb/test_raster_sync_gen.sv
module test_raster_sync_gen;
  localparam int F525 = 6, F625 = 7, B525 = 2, B625 = 3, VSL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic std_625 = 0, pal_full = 0, clk_family = 0, interlace = 0, add_half = 0;
  logic hsync_n, vsync_n, burst_gate, active_gate, field_odd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  raster_sync_gen #(.FIELD_525(F525), .FIELD_625(F625), .BLANK_525(B525),
                    .BLANK_625(B625), .VSYNC_LINES(VSL)) i_raster_sync_gen (
    .clk(clk), .rst_n(rst_n), .std_625(std_625), .pal_full(pal_full),
    .clk_family(clk_family), .interlace(interlace), .add_half(add_half),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .burst_gate(burst_gate),
    .active_gate(active_gate), .field_odd(field_odd)
  );

  // std: 0 NTSC, 1 PAL, 2 PAL60 (R1 decode)
  function automatic int std_of(logic s, logic p);
    return !s ? 0 : (p ? 1 : 2);
  endfunction
  function automatic int frame_len(int sd, logic i, logic a);
    int f = (sd == 1) ? F625 : F525;
    return i ? 2 * f + 1 : f + int'(a);
  endfunction
  function automatic int line_len(int sd, logic fam);
    if (sd == 0) return fam ? 910 : 858;
    if (sd == 1) return fam ? 908 : 864;
    return fam ? 902 : 858;
  endfunction
  // returns {hsync_n, vsync_n, burst, active, field_odd}
  function automatic logic [4:0] model(int k, int sd, logic fam, logic i, logic a);
    int l = line_len(sd, fam);
    int f = (sd == 1) ? F625 : F525;
    int bl = (sd == 1) ? B625 : B525;
    int h = k % l;
    int ln = (k / l) % frame_len(sd, i, a);
    int vp = ln * l + h;
    int half = l / 2;
    int se = fam ? 67 : 64;
    int bb = fam ? ((sd == 0) ? 76 : 75) : 71;
    int be = fam ? 112 : 106;
    int ab = (sd == 1) ? (fam ? 149 : 142) : (fam ? 135 : 128);
    logic blank = (ln < bl) || (i && ln >= f && ln <= f + bl);
    logic vs = (vp < VSL * l) || (i && vp >= f * l + half && vp < (f + VSL) * l + half);
    logic even = i && (vp >= f * l + half);
    return {!(h < se), !vs, (h >= bb && h < be), (h >= ab && !blank), !even};
  endfunction

  task automatic chk(string req, string nm, logic act, logic exp, int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pixel index %0d: got %b expected %b", req, nm, k, act, exp);
    end
  endtask

  task automatic run_mode(logic s, logic p, logic fam, logic i, logic a);
    int sd = std_of(s, p);
    int n = (frame_len(sd, i, a) + 1) * line_len(sd, fam);
    @(negedge clk);
    rst_n = 1'b0; std_625 = s; pal_full = p; clk_family = fam; interlace = i; add_half = a;
    repeat (3) @(negedge clk);
    chk("R9", "hsync_n in reset", hsync_n, 1'b1, -1);
    chk("R9", "vsync_n in reset", vsync_n, 1'b1, -1);
    chk("R9", "burst in reset", burst_gate, 1'b0, -1);
    chk("R9", "active in reset", active_gate, 1'b0, -1);
    chk("R9", "field in reset", field_odd, 1'b1, -1);
    rst_n = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic [4:0] e;
      @(negedge clk);
      e = model(k, sd, fam, i, a);
      chk("R1 R2 R9", "hsync_n", hsync_n, e[4], k);
      chk(i ? "R5 R7" : "R6 R7", "vsync_n", vsync_n, e[3], k);
      chk("R3", "burst_gate", burst_gate, e[2], k);
      chk("R4", "active_gate", active_gate, e[1], k);
      chk("R8", "field_odd", field_odd, e[0], k);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    run_mode(0, 0, 0, 1, 0); // NTSC first family interlaced
    run_mode(1, 1, 1, 1, 0); // PAL second family interlaced
    run_mode(1, 0, 1, 0, 0); // PAL60 progressive short
    run_mode(0, 0, 1, 0, 1); // NTSC progressive long
    run_mode(1, 1, 0, 0, 1); // PAL first family progressive long
    run_mode(1, 0, 0, 1, 1); // PAL60 interlaced, add_half ignored
    for (int r = 0; r < 2; r++) begin
      logic [4:0] m = 5'($urandom());
      run_mode(m[0], m[1], m[2], m[3], m[4]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule